// File: doc/BRIEF.md
# 64b/66b Payload Scrambler

This block applies the self-synchronizing multiplicative scrambler of 64b/66b line coding to one 64-bit payload word per clock. Each scrambled bit is the matching data bit XORed with the scrambled bits 39 and 58 positions earlier in the serial stream. Because the history is made of scrambled bits rather than a free-running sequence, a receiver that shifts in the scrambled bits it sees locks on after 58 bits. It needs no shared seed.

Bit 0 of the word is the first bit on the line. All 64 bits are processed in one cycle. The result is registered. A word is taken only on cycles where the valid strobe is high. The two-bit sync header bypasses this block.

Top module: `scr64_scrambler`

## Requirements
- R1: While reset is high, the output register is cleared to zero. The zero is visible on the first cycle after reset is released.
- R2: Scrambled bit n equals data bit n XOR scrambled bit n-39 XOR scrambled bit n-58, counted over the serial stream. Word bit 0 comes first. The history continues across word boundaries.
- R3: After reset, the 58-bit history equals the seed parameter, which defaults to all ones. The seed's bit k stands for the scrambled bit k+1 positions before the first bit. With the default seed, an all-zero first word scrambles to 64'h03FFFF8000000000.
- R4: On a cycle with the valid strobe low, the data input is ignored, the output word holds, and the history does not advance.
- R5: A word accepted at a clock edge appears on the output right after that same edge. It stays there until the next accepted word or reset.
- R6: A reset in mid-stream returns the history to the seed. The next word scrambles as it would first after power-up.
- R7: A descrambler that starts from any history recovers the original data from the second accepted word onward. The descrambler applies the same taps to the received scrambled bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 64 | Payload word; bit 0 is sent first |
| din_vld | input | 1 | Accept din on this edge |
| dout | output | 64 | Registered scrambled word |

## Verification
The bench targets the word seam, where bits 0 to 57 take their taps from the previous word. A design that reset or mis-indexed the carried history would match only the first word and then drift. It starts from the all-ones seed with zero data, which exposes a reversed seed or reversed bit order as a wrong fixed constant. Random gaps with garbage on the input catch a history that advances or an output that changes while the strobe is low. A reset in mid-stream and a descrambler that starts out of step confirm that the stream recovers.

// File: rtl/scr64_scrambler.sv
`timescale 1ns / 1ps
module scr64_scrambler #(
  parameter int DATA_W = 64,
  parameter int STATE_W = 58,
  parameter int TAP_A = 39,
  parameter logic [STATE_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              din_vld,
  output logic [DATA_W-1:0] dout
);
  localparam int EXT_W = STATE_W + DATA_W;

  // ext[STATE_W-1:0]: history, oldest at index 0; ext[EXT_W-1:STATE_W]: new bits in line order
  function automatic logic [EXT_W-1:0] unroll(input logic [STATE_W-1:0] st,
                                              input logic [DATA_W-1:0] d);
    logic [EXT_W-1:0] e;
    e = '0;
    for (int k = 0; k < STATE_W; k++) e[STATE_W-1-k] = st[k];
    for (int i = 0; i < DATA_W; i++)
      e[STATE_W+i] = d[i] ^ e[STATE_W+i-TAP_A] ^ e[i];
    return e;
  endfunction

  logic [STATE_W-1:0] state_q, state_nx;
  logic [DATA_W-1:0]  dout_q;
  logic [EXT_W-1:0]   ext;

  assign ext  = unroll(state_q, din);
  assign dout = dout_q;

  always_comb
    for (int k = 0; k < STATE_W; k++) state_nx[k] = ext[EXT_W-1-k];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
      dout_q  <= '0;
    end else if (din_vld) begin
      state_q <= state_nx;
      dout_q  <= ext[EXT_W-1:STATE_W];
    end
  end
endmodule

// File: rtl/scr64_scrambler_chk.sv
`timescale 1ns / 1ps
module scr64_scrambler_chk #(
  parameter int DATA_W = 64,
  parameter int STATE_W = 58,
  parameter int TAP_A = 39,
  parameter logic [STATE_W-1:0] SEED = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              din_vld,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout
);
  function automatic logic [STATE_W-1:0] flip(input logic [STATE_W-1:0] v);
    logic [STATE_W-1:0] r;
    for (int k = 0; k < STATE_W; k++) r[k] = v[STATE_W-1-k];
    return r;
  endfunction

  localparam logic [STATE_W-1:0] SEED_REV = flip(SEED);

  logic primed;
  always_ff @(posedge clk)
    if (rst) primed <= 1'b0;
    else if (din_vld) primed <= 1'b1;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dout == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !din_vld |=> $stable(dout));

  // R2
  seam_taps_chk: assert property (@(posedge clk) disable iff (rst)
    (din_vld && primed) |=> ((dout ^ $past(din)) ==
      ({dout[DATA_W-TAP_A-1:0], $past(dout[DATA_W-1:DATA_W-TAP_A])} ^
       {dout[DATA_W-STATE_W-1:0], $past(dout[DATA_W-1:DATA_W-STATE_W])})));

  // R3
  seed_taps_chk: assert property (@(posedge clk) disable iff (rst)
    (din_vld && !primed) |=> ((dout ^ $past(din)) ==
      ({dout[DATA_W-TAP_A-1:0], SEED_REV[STATE_W-1:STATE_W-TAP_A]} ^
       {dout[DATA_W-STATE_W-1:0], SEED_REV})));
endmodule

bind scr64_scrambler scr64_scrambler_chk #(
  .DATA_W(DATA_W), .STATE_W(STATE_W), .TAP_A(TAP_A), .SEED(SEED)
) u_chk (
  .clk(clk), .rst(rst), .din_vld(din_vld), .din(din), .dout(dout)
);

// File: tb/scr64_scrambler_test.sv
`timescale 1ns / 1ps
module scr64_scrambler_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        din_vld = 1'b0;
  logic [63:0] din = '0;
  logic [63:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit fresh = 1'b1;

  logic [57:0] ms = '1;
  logic [57:0] dsr = 58'h0123456789abcde;
  logic [63:0] exp_q[$];
  logic [63:0] org_q[$];
  bit          skip_q[$];
  logic        vld_q = 1'b0;

  scr64_scrambler uut (
    .clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .dout(dout)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [63:0] d);
    logic [63:0] s;
    logic b;
    s = '0;
    for (int i = 0; i < 64; i++) begin
      b = d[i] ^ ms[38] ^ ms[57];
      s[i] = b;
      ms = {ms[56:0], b};
    end
    exp_q.push_back(s);
    org_q.push_back(d);
    skip_q.push_back(fresh);
    fresh = 1'b0;
    din = d;
    din_vld = 1'b1;
    @(negedge clk);
    din_vld = 1'b0;
    din = ~d;
  endtask

  task automatic idle(input int n);
    logic [63:0] hold;
    hold = dout;
    for (int j = 0; j < n; j++) begin
      din = {$urandom, $urandom};
      @(negedge clk);
      check(dout == hold, "R4 output held while strobe low", dout, hold);
    end
  endtask

  always @(posedge clk) vld_q <= din_vld && !rst;

  always @(negedge clk) begin
    if (vld_q) begin
      logic [63:0] e, o, r;
      bit sk;
      e = exp_q.pop_front();
      o = org_q.pop_front();
      sk = skip_q.pop_front();
      check(dout == e, "R2/R5 scrambled word", dout, e);
      for (int i = 0; i < 64; i++) begin
        r[i] = dout[i] ^ dsr[38] ^ dsr[57];
        dsr = {dsr[56:0], dout[i]};
      end
      if (!sk) check(r == o, "R7 round trip", r, o);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dout == '0, "R1 reset value", dout, 64'h0);

    send(64'h0);
    check(dout == 64'h03FFFF8000000000, "R3 seed with zero data", dout, 64'h03FFFF8000000000);
    send(64'hFFFFFFFFFFFFFFFF);
    send(64'hAAAAAAAA55555555);
    for (int b = 0; b < 64; b += 7) send(64'h1 << b);
    idle(3);
    send(64'h0123456789ABCDEF);

    for (int k = 0; k < 300; k++) begin
      send({$urandom, $urandom});
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    ms = '1;
    fresh = 1'b1;
    check(dout == '0, "R6/R1 mid-stream reset clears", dout, 64'h0);
    send(64'h0);
    check(dout == 64'h03FFFF8000000000, "R6 history back to seed", dout, 64'h03FFFF8000000000);
    for (int k = 0; k < 50; k++) send({$urandom, $urandom});

    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R5 every word produced", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule